// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side each have their own clock, so the two sides can share one clock or run with no fixed phase relation. Storage depth is a parameter; the default is 256 words, and any power of two from 16 to 8192 is supported. A write needs a pair of enables. A read also needs a pair of enables. The second write enable has two possible roles. Its level while reset is held picks the role: it either stays a write enable, or it becomes an active-low load strobe that a neighbouring offset-register block watches.

The block drives four status flags. Empty and almost-empty come from the read clock domain. Full and almost-full come from the write clock domain. The two almost flags compare the fill level against two thresholds that arrive on input ports. Each pointer crosses to the other clock domain as Gray code through a two-stage synchroniser. The read word is held in a register. An output-enable input decides whether that word is driven onto the data port; when it is not driven, the port reads zero and a drive-enable output goes low.

Top module: `dcfifo_pf`

## Requirements
- R1: Data is 9 bits wide, and words leave in the same order they were accepted. DEPTH is a power-of-two parameter with a default of 256.
- R2: While in second-enable mode, a write happens on a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both high. If either one is low, the write is blocked.
- R3: `wr_en_b` is sampled on every `wr_clk` edge while `rst_n` is low. If it was high, it stays a second write enable. If it was low, load mode is selected. In load mode only `wr_en_a` gates writes, and `ofs_load` = 1 exactly while `wr_en_b` is low.
- R4: `full` is 1 when the write-side fill level equals DEPTH. This happens after exactly DEPTH accepted writes with no reads since reset. A write attempt while `full` is 1 changes nothing.
- R5: `almost_empty` is 1 when the read-side level is at or below `ae_ofs`. `almost_full` is 1 when the write-side level is at or above DEPTH − `af_ofs`.
- R6: A read happens on a rising `rd_clk` edge only when `rd_en_a`, `rd_en_b` and not-empty all hold. The word read is registered, so it appears on `rd_data` after that edge and is held until the next accepted read.
- R7: An accepted write turns `empty` low after the second `rd_clk` edge that follows the write edge. An accepted read turns `full` low after the second `wr_clk` edge that follows the read edge. Pointers cross between the domains as Gray code, which changes at most one bit per edge.
- R8: While `rst_n` is low (asynchronous, active low), the pointers are cleared. `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, and the registered read word is zero.
- R9: `rd_data_oe` follows `out_en`. When `out_en` is 0, `rd_data` is all zeros. When `out_en` is 1, `rd_data` shows the registered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable, or active-low load strobe (strap at reset) |
| wr_data | input | 9 | Word to store |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Drive enable for the read data port |
| ae_ofs | input | log2(DEPTH) | Almost-empty threshold |
| af_ofs | input | log2(DEPTH) | Almost-full distance from full |
| rd_data | output | 9 | Registered read word, zero when not driven |
| rd_data_oe | output | 1 | High while `rd_data` is driven |
| ofs_load | output | 1 | Load strobe seen in load mode |
| empty | output | 1 | No word visible to the read side |
| almost_empty | output | 1 | Read-side level at or below `ae_ofs` |
| full | output | 1 | Write-side level equals DEPTH |
| almost_full | output | 1 | Write-side level at or above DEPTH − `af_ofs` |

## Verification
Results arrive at different times, so each is checked at its own time.

- A read word is due after the read edge that accepted it.
- The flag on the side that acted moves after that same edge. The flag on the opposite side moves two edges later, which is the synchroniser delay.
- `rd_data`, `rd_data_oe`, `ofs_load` and the threshold comparisons follow the current values of `out_en`, `wr_en_b` and the offsets within the same cycle.

The bench runs both ports on one shared clock. It keeps separate write, read and delayed-pointer counts that reproduce this two-edge lag. It changes inputs on the falling edge and compares every output at the following falling edge, after the model has been advanced for the rising edge in between.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  localparam int unsigned DATA_W = 9;

  typedef logic [DATA_W-1:0] word_t;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram import dcfifo_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);

  word_t mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl import dcfifo_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [PW-1:0] rgray_s,
  input  logic [AW-1:0] af_ofs,
  output logic          go,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray,
  output logic [PW-1:0] lvl,
  output logic          full,
  output logic          almost_full
);

  logic [PW-1:0] rbin_s;
  logic [PW-1:0] bin_q;
  logic [PW-1:0] gray_q;
  logic [PW-1:0] bin_nx;
  logic [PW-1:0] af_thr;

  assign rbin_s      = PW'(gray2bin(32'(rgray_s)));
  assign lvl         = bin_q - rbin_s;
  assign af_thr      = PW'(DEPTH) - PW'(af_ofs);
  assign full        = (lvl == PW'(DEPTH));
  assign almost_full = (lvl >= af_thr);
  assign go          = req & ~full;
  assign bin_nx      = bin_q + PW'(go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= PW'(bin2gray(32'(bin_nx)));
    end
  end

  assign bin  = bin_q;
  assign gray = gray_q;

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl import dcfifo_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [PW-1:0] wgray_s,
  input  logic [AW-1:0] ae_ofs,
  input  word_t         ram_q,
  output logic          go,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray,
  output logic [PW-1:0] lvl,
  output logic          empty,
  output logic          almost_empty,
  output word_t         rd_q
);

  logic [PW-1:0] wbin_s;
  logic [PW-1:0] bin_q;
  logic [PW-1:0] gray_q;
  logic [PW-1:0] bin_nx;
  word_t         word_q;

  assign wbin_s       = PW'(gray2bin(32'(wgray_s)));
  assign lvl          = wbin_s - bin_q;
  assign empty        = (lvl == '0);
  assign almost_empty = (lvl <= PW'(ae_ofs));
  assign go           = req & ~empty;
  assign bin_nx       = bin_q + PW'(go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      word_q <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_q <= PW'(bin2gray(32'(bin_nx)));
      if (go) begin
        word_q <= ram_q;
      end
    end
  end

  assign bin  = bin_q;
  assign gray = gray_q;
  assign rd_q = word_q;

endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf import dcfifo_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_a,
  input  logic              wr_en_b,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              out_en,
  input  logic [AW-1:0]     ae_ofs,
  input  logic [AW-1:0]     af_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_oe,
  output logic              ofs_load,
  output logic              empty,
  output logic              almost_empty,
  output logic              full,
  output logic              almost_full
);

  localparam int PW = AW + 1;

  logic          load_mode;
  logic          wr_req;
  logic          rd_req;
  logic          wr_go;
  logic          rd_go;
  logic [PW-1:0] wbin;
  logic [PW-1:0] rbin;
  logic [PW-1:0] wgray;
  logic [PW-1:0] rgray;
  logic [PW-1:0] wgray_s;
  logic [PW-1:0] rgray_s;
  logic [PW-1:0] wr_lvl;
  logic [PW-1:0] rd_lvl;
  word_t         ram_q;
  word_t         rd_q;

  // Strap: the role of wr_en_b is captured while reset is held.
  always_ff @(posedge wr_clk) begin
    if (!rst_n) begin
      load_mode <= ~wr_en_b;
    end
  end

  assign wr_req   = wr_en_a & (load_mode | wr_en_b);
  assign ofs_load = load_mode & ~wr_en_b;
  assign rd_req   = rd_en_a & rd_en_b;

  dcfifo_sync #(.W(PW)) u_w2r (
    .clk   (rd_clk),
    .rst_n (rst_n),
    .d     (wgray),
    .q     (wgray_s)
  );

  dcfifo_sync #(.W(PW)) u_r2w (
    .clk   (wr_clk),
    .rst_n (rst_n),
    .d     (rgray),
    .q     (rgray_s)
  );

  dcfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wctl (
    .clk         (wr_clk),
    .rst_n       (rst_n),
    .req         (wr_req),
    .rgray_s     (rgray_s),
    .af_ofs      (af_ofs),
    .go          (wr_go),
    .bin         (wbin),
    .gray        (wgray),
    .lvl         (wr_lvl),
    .full        (full),
    .almost_full (almost_full)
  );

  dcfifo_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rctl (
    .clk          (rd_clk),
    .rst_n        (rst_n),
    .req          (rd_req),
    .wgray_s      (wgray_s),
    .ae_ofs       (ae_ofs),
    .ram_q        (ram_q),
    .go           (rd_go),
    .bin          (rbin),
    .gray         (rgray),
    .lvl          (rd_lvl),
    .empty        (empty),
    .almost_empty (almost_empty),
    .rd_q         (rd_q)
  );

  dcfifo_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk  (wr_clk),
    .we    (wr_go),
    .waddr (wbin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rbin[AW-1:0]),
    .rdata (ram_q)
  );

  assign rd_data_oe = out_en;
  assign rd_data    = out_en ? rd_q : '0;

endmodule

// File: rtl/dcfifo_pf_chk.sv
module dcfifo_pf_chk import dcfifo_pkg::*; #(
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          rd_go,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] wr_lvl,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input word_t         rd_q
);

  AST_FULL_HOLDS_WPTR: assert property (@(posedge wr_clk) disable iff (!rst_n) full |=> $stable(wbin)); // R4
  AST_LEVEL_CAP: assert property (@(posedge wr_clk) disable iff (!rst_n) wr_lvl <= PW'(DEPTH)); // R4
  AST_EMPTY_HOLDS_RPTR: assert property (@(posedge rd_clk) disable iff (!rst_n) empty |=> $stable(rbin)); // R6
  AST_RDQ_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n) !rd_go |=> $stable(rd_q)); // R6
  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!rst_n) full |-> almost_full); // R5
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rst_n) empty |-> almost_empty); // R5
  AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!rst_n) $onehot0(wgray ^ $past(wgray))); // R7
  AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rst_n) $onehot0(rgray ^ $past(rgray))); // R7

endmodule

bind dcfifo_pf dcfifo_pf_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .wr_clk       (wr_clk),
  .rd_clk       (rd_clk),
  .rst_n        (rst_n),
  .rd_go        (rd_go),
  .wbin         (wbin),
  .rbin         (rbin),
  .wgray        (wgray),
  .rgray        (rgray),
  .wr_lvl       (wr_lvl),
  .full         (full),
  .almost_full  (almost_full),
  .empty        (empty),
  .almost_empty (almost_empty),
  .rd_q         (rd_q)
);

// File: tb/dcfifo_pf_tb.sv
module dcfifo_pf_tb;

  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en_a, wr_en_b, rd_en_a, rd_en_b, out_en;
  logic [8:0]    wr_data;
  logic [AW-1:0] ae_ofs, af_ofs;
  logic [8:0]    rd_data;
  logic          rd_data_oe, ofs_load, empty, almost_empty, full, almost_full;

  always #5 clk = ~clk;

  dcfifo_pf #(.DEPTH(DEPTH)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n),
    .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .ofs_load(ofs_load),
    .empty(empty), .almost_empty(almost_empty),
    .full(full), .almost_full(almost_full)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Behavioural reference: data queue plus accepted-write/read counts,
  // with two-edge delayed copies standing for each crossing.
  logic [8:0] q[$];
  int         wcnt, rcnt, ws1, ws2, rs1, rs2;
  logic [8:0] rdq;
  bit         mode;

  function automatic int m_wl();
    return wcnt - rs2;
  endfunction

  function automatic int m_rl();
    return ws2 - rcnt;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4 full", int'(full), int'(m_wl() == DEPTH));
    chk("R5 almost_full", int'(almost_full), int'(m_wl() >= DEPTH - int'(af_ofs)));
    chk("R7 empty", int'(empty), int'(m_rl() == 0));
    chk("R5 almost_empty", int'(almost_empty), int'(m_rl() <= int'(ae_ofs)));
    chk("R1/R6 rd_data", int'(rd_data), out_en ? int'(rdq) : 0);
    chk("R9 rd_data_oe", int'(rd_data_oe), int'(out_en));
    chk("R3 ofs_load", int'(ofs_load), int'(mode && !wr_en_b));
  endtask

  // Called at a falling edge: check, drive, advance the model, wait.
  task automatic step(input bit a, input bit b, input bit ra, input bit rb,
                      input bit oe, input int ae, input int af);
    bit wgo, rgo;
    logic [8:0] d;
    compare_all();
    d       = 9'($urandom);
    wr_en_a = a;  wr_en_b = b;  rd_en_a = ra;  rd_en_b = rb;
    out_en  = oe; ae_ofs = AW'(ae); af_ofs = AW'(af); wr_data = d;
    wgo = a && (mode || b) && (m_wl() != DEPTH);   // R2 R4
    rgo = ra && rb && (m_rl() != 0);               // R6
    if (rgo) rdq = q.pop_front();
    if (wgo) q.push_back(d);
    ws2 = ws1; ws1 = wcnt;
    rs2 = rs1; rs1 = rcnt;
    wcnt += int'(wgo);
    rcnt += int'(rgo);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit strap);
    rst_n = 1'b0;
    wr_en_a = 0; wr_en_b = strap; rd_en_a = 0; rd_en_b = 0;
    out_en = 1; ae_ofs = 7; af_ofs = 7; wr_data = '0;
    repeat (3) @(negedge clk);
    q.delete();
    wcnt = 0; rcnt = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
    rdq = '0; mode = !strap;
    chk("R8 empty in reset", int'(empty), 1);
    chk("R8 almost_empty in reset", int'(almost_empty), 1);
    chk("R8 full in reset", int'(full), 0);
    chk("R8 almost_full in reset", int'(almost_full), 0);
    chk("R8 rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // Normal mode: wr_en_b high during reset.
    do_reset(1'b1);
    repeat (20) step(1, 1, 0, 0, 1, 7, 7);
    chk("R4 full after DEPTH writes", int'(full), 1);
    chk("R4 level kept at DEPTH", wcnt, DEPTH);
    repeat (4) step(0, 0, 1, 1, 1, 7, 7);
    repeat (3) step(1, 0, 0, 0, 1, 7, 7);     // R2 blocked by wr_en_b
    repeat (3) step(0, 1, 0, 0, 1, 7, 7);     // R2 blocked by wr_en_a
    chk("R2 no write with one enable", wcnt, DEPTH);
    for (int k = 0; k < 30; k++) begin
      step(0, 0, 1, (k % 3) != 0, (k % 5) != 0, 3, 2);  // R6 R9
    end
    chk("R7 empty after drain", int'(empty), 1);
    for (int k = 0; k < 3000; k++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0,
           $urandom_range(0, 2) != 0, $urandom_range(0, 5) != 0,
           $urandom_range(0, 7) != 0,
           (k < 1500) ? 7 : $urandom_range(0, 15),
           (k < 1500) ? 7 : $urandom_range(0, 15));
    end
    // Load mode: wr_en_b low during reset.
    do_reset(1'b0);
    step(1, 0, 0, 0, 1, 7, 7);
    chk("R3 ofs_load while strobe low", int'(ofs_load), 1);
    chk("R3 write with only wr_en_a", wcnt, 1);
    for (int k = 0; k < 60; k++) begin
      step(1, $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0, 1, 1, 7, 7);
    end
    compare_all();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule